// File: doc/BRIEF.md
# Digit-Strobe Multiplexed Setting Decoder

This block recovers a counter's configuration from a handful of single input lines. Each line is strapped back to one or more of the display's digit strobes. While the digit scan runs, the decoder samples every line once per digit slot, late in the slot, and records which digit was active on which line. From that it builds four things: the measurement function, the range step, a set of control flags, and the digit that carries an external decimal point.

A complete scan runs from digit 1 to digit 8 and ends on the sample taken in the digit 8 slot. A scan result is committed only when two scans in a row agree, so a single scan disturbed by coupled display noise never reaches the outputs. The control line may be strapped to several digits at the same time, so its flags are gathered over the whole scan. When the committed function or range takes a new value, a one-cycle change pulse tells the measurement sequencer to abort and restart. Display-off mode needs the hold input as well. While display-off is in effect the lines are ignored, and decoding starts again from scratch once hold is released.

Top module: `mux_ctl_decoder`

## Requirements
- R1: After reset, `func` is 0 (frequency), `range_sel` is 0, every control flag is 0, `xdp_valid` is 0 and `cfg_chg` is 0.
- R2: A line is sampled only in a cycle where `sample_stb` is high. Line activity in cycles with `sample_stb` low has no effect on any output.
- R3: `digit_idx` value k stands for digit D(k+1). The function is coded by the digit active on the function line: D1→0 frequency, D8→1 period, D2→2 ratio, D5→3 time interval, D4→4 unit counter, D3→5 oscillator self-test. If several function digits are seen in one scan, the one sampled last wins.
- R4: On the range line, D1, D2, D3 and D4 select `range_sel` 0, 1, 2 and 3. Other digits are ignored, and if several range digits are seen, the last one sampled wins.
- R5: Control flags are gathered over the whole scan, and every digit seen on the control line sets its own flag: D8→`disp_test`, D2→`sel_1mhz`, D1→`ext_osc`, D3→`xdp_en`, D4→display off.
- R6: With `active_low` at 0 a line is active when high. With `active_low` at 1 it is active when low.
- R7: The external decimal point digit is the last non-D8 digit seen active on that line (`xdp_digit` holds its `digit_idx`, and `xdp_valid` is 1). D8 on that line is rejected.
- R8: A scan ends on the sample with `digit_idx` = 7. Outputs update on that edge, and only when the result of that scan equals the result of the scan before it.
- R9: `cfg_chg` is high for exactly one cycle, right after a commit that changes `func` or `range_sel`, and stays low after a commit that changes neither.
- R10: A committed scan with no function digit leaves `func` unchanged, and one with no range digit leaves `range_sel` unchanged.
- R11: `disp_off` is set only when the agreed scan has D4 on the control line and `hold` is high at the commit. While `disp_off` is high, all lines are ignored. One cycle after `hold` is low, `disp_off` clears, and two fresh agreeing scans are needed before the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_idx | input | 3 | Current digit slot, 0 = D1 … 7 = D8 |
| sample_stb | input | 1 | Late-slot sample strobe |
| active_low | input | 1 | Line polarity: 1 = lines active low |
| hold | input | 1 | Hold input, qualifies display off |
| fn_line | input | 1 | Function select line |
| rng_line | input | 1 | Range select line |
| ctl_line | input | 1 | Control line, may be tied to several digits |
| xdp_line | input | 1 | External decimal point line |
| func | output | 3 | Committed function code |
| range_sel | output | 2 | Committed range step |
| disp_off | output | 1 | Display off in effect |
| disp_test | output | 1 | Display test flag |
| sel_1mhz | output | 1 | 1 MHz timebase select flag |
| ext_osc | output | 1 | External oscillator enable flag |
| xdp_en | output | 1 | External decimal point enable flag |
| xdp_valid | output | 1 | An external decimal point digit is selected |
| xdp_digit | output | 3 | Selected external decimal point digit index |
| cfg_chg | output | 1 | One-cycle pulse on function or range change |

## Verification
A corrupt scan accumulator or a misaligned scan boundary shows up as a wrong code on `func`, `range_sel`, the flags or `xdp_digit` right after the digit 8 sample of the second agreeing scan. In the worst case it shows up as a commit one scan early, which the bench catches by checking after the first scan of each pair. A broken agreement register commits on a single scan, and a broken display-off path lets settings move while the display is off. Both are visible within one scan of the stimulus. A wrong change comparator shows as `cfg_chg` firing on an unchanged commit or staying silent on a real change, in the cycle right after the commit edge.

// File: rtl/mux_ctl_decoder.sv
module mux_ctl_decoder #(
  parameter int NDIG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NDIG)-1:0] digit_idx,
  input  logic                    sample_stb,
  input  logic                    active_low,
  input  logic                    hold,
  input  logic                    fn_line,
  input  logic                    rng_line,
  input  logic                    ctl_line,
  input  logic                    xdp_line,
  output logic [2:0]              func,
  output logic [1:0]              range_sel,
  output logic                    disp_off,
  output logic                    disp_test,
  output logic                    sel_1mhz,
  output logic                    ext_osc,
  output logic                    xdp_en,
  output logic                    xdp_valid,
  output logic [$clog2(NDIG)-1:0] xdp_digit,
  output logic                    cfg_chg
);
  localparam int DW = $clog2(NDIG);
  localparam logic [DW-1:0] LAST = DW'(NDIG - 1);

  typedef struct packed {
    logic          fn_v;
    logic [2:0]    fn;
    logic          rg_v;
    logic [1:0]    rg;
    logic          off;
    logic          tst;
    logic          mhz;
    logic          eosc;
    logic          xen;
    logic          xd_v;
    logic [DW-1:0] xd;
  } scan_t;

  scan_t acc, prv, nxt;
  logic  prv_v;

  wire f_a = fn_line  ^ active_low;
  wire r_a = rng_line ^ active_low;
  wire c_a = ctl_line ^ active_low;
  wire x_a = xdp_line ^ active_low;

  wire samp     = sample_stb && !disp_off;
  wire scan_end = samp && digit_idx == LAST;
  wire agree    = prv_v && prv == nxt;

  always_comb begin
    nxt = acc;
    case (digit_idx)
      DW'(0): begin
        if (f_a) begin nxt.fn_v = 1'b1; nxt.fn = 3'd0; end
        if (r_a) begin nxt.rg_v = 1'b1; nxt.rg = 2'd0; end
        if (c_a) nxt.eosc = 1'b1;
      end
      DW'(1): begin
        if (f_a) begin nxt.fn_v = 1'b1; nxt.fn = 3'd2; end
        if (r_a) begin nxt.rg_v = 1'b1; nxt.rg = 2'd1; end
        if (c_a) nxt.mhz = 1'b1;
      end
      DW'(2): begin
        if (f_a) begin nxt.fn_v = 1'b1; nxt.fn = 3'd5; end
        if (r_a) begin nxt.rg_v = 1'b1; nxt.rg = 2'd2; end
        if (c_a) nxt.xen = 1'b1;
      end
      DW'(3): begin
        if (f_a) begin nxt.fn_v = 1'b1; nxt.fn = 3'd4; end
        if (r_a) begin nxt.rg_v = 1'b1; nxt.rg = 2'd3; end
        if (c_a) nxt.off = 1'b1;
      end
      DW'(4): begin
        if (f_a) begin nxt.fn_v = 1'b1; nxt.fn = 3'd3; end
      end
      LAST: begin
        if (f_a) begin nxt.fn_v = 1'b1; nxt.fn = 3'd1; end
        if (c_a) nxt.tst = 1'b1;
      end
      default: ;
    endcase
    if (x_a && digit_idx != LAST) begin
      nxt.xd_v = 1'b1;
      nxt.xd   = digit_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      prv       <= '0;
      prv_v     <= 1'b0;
      func      <= 3'd0;
      range_sel <= 2'd0;
      disp_off  <= 1'b0;
      disp_test <= 1'b0;
      sel_1mhz  <= 1'b0;
      ext_osc   <= 1'b0;
      xdp_en    <= 1'b0;
      xdp_valid <= 1'b0;
      xdp_digit <= '0;
      cfg_chg   <= 1'b0;
    end else begin
      cfg_chg <= 1'b0;
      if (disp_off) begin
        acc   <= '0;
        prv_v <= 1'b0;
        if (!hold) disp_off <= 1'b0;
      end else if (scan_end) begin
        acc   <= '0;
        prv   <= nxt;
        prv_v <= 1'b1;
        if (agree) begin
          if (nxt.fn_v) func <= nxt.fn;
          if (nxt.rg_v) range_sel <= nxt.rg;
          disp_off  <= nxt.off && hold;
          disp_test <= nxt.tst;
          sel_1mhz  <= nxt.mhz;
          ext_osc   <= nxt.eosc;
          xdp_en    <= nxt.xen;
          xdp_valid <= nxt.xd_v;
          xdp_digit <= nxt.xd;
          cfg_chg   <= (nxt.fn_v && nxt.fn != func) || (nxt.rg_v && nxt.rg != range_sel);
        end
      end else if (samp) begin
        acc <= nxt;
      end
    end
  end

  AST_FUNC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    func <= 3'd5);  // R3
  AST_XDP_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    xdp_valid |-> xdp_digit != LAST);  // R7
  AST_MOVE_AT_SCAN_END: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(func) && $stable(range_sel)) |-> $past(sample_stb && digit_idx == LAST));  // R8
  AST_CHG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !cfg_chg);  // R9
  AST_CHG_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |-> (func != $past(func) || range_sel != $past(range_sel)));  // R9
  AST_CHG_WHEN_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> ($stable(func) && $stable(range_sel)));  // R9
  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disp_off) |-> ($stable(func) && $stable(range_sel) && $stable(xdp_digit)));  // R11
  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off && !hold) |=> !disp_off);  // R11
endmodule

// File: tb/mux_ctl_decoder_bench.sv
module mux_ctl_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] digit_idx = '0;
  logic sample_stb = 1'b0, active_low = 1'b0, hold = 1'b0;
  logic fn_line = 1'b0, rng_line = 1'b0, ctl_line = 1'b0, xdp_line = 1'b0;
  logic [2:0] func, xdp_digit;
  logic [1:0] range_sel;
  logic disp_off, disp_test, sel_1mhz, ext_osc, xdp_en, xdp_valid, cfg_chg;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic last_chg;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_ctl_decoder u_mux_ctl_decoder (
    .clk(clk), .rst_n(rst_n), .digit_idx(digit_idx), .sample_stb(sample_stb),
    .active_low(active_low), .hold(hold), .fn_line(fn_line), .rng_line(rng_line),
    .ctl_line(ctl_line), .xdp_line(xdp_line), .func(func), .range_sel(range_sel),
    .disp_off(disp_off), .disp_test(disp_test), .sel_1mhz(sel_1mhz), .ext_osc(ext_osc),
    .xdp_en(xdp_en), .xdp_valid(xdp_valid), .xdp_digit(xdp_digit), .cfg_chg(cfg_chg));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic scan(input logic [7:0] fm, rm, cm, xm, input bit noise);
    for (int d = 0; d < 8; d++) begin
      if (noise) begin
        @(negedge clk);
        digit_idx = 3'(d); sample_stb = 1'b0;
        fn_line = ~active_low; rng_line = ~active_low;
        ctl_line = ~active_low; xdp_line = ~active_low;
      end
      @(negedge clk);
      digit_idx = 3'(d); sample_stb = 1'b1;
      fn_line  = fm[d] ^ active_low;
      rng_line = rm[d] ^ active_low;
      ctl_line = cm[d] ^ active_low;
      xdp_line = xm[d] ^ active_low;
    end
    @(negedge clk);
    sample_stb = 1'b0;
    fn_line = active_low; rng_line = active_low; ctl_line = active_low; xdp_line = active_low;
    last_chg = cfg_chg;
  endtask

  task automatic t_reset();
    check("R1 func", func, 0);
    check("R1 range", range_sel, 0);
    check("R1 flags", {disp_off, disp_test, sel_1mhz, ext_osc, xdp_en}, 0);
    check("R1 xdp_valid", xdp_valid, 0);
    check("R1 chg", cfg_chg, 0);
  endtask

  task automatic t_agree();
    scan(8'h80, 8'h04, 0, 0, 0);
    check("R8 single scan no commit", func, 0);
    check("R8 single scan no chg", last_chg, 0);
    scan(8'h80, 8'h04, 0, 0, 0);
    check("R8 func period", func, 1);
    check("R4 range D3", range_sel, 2);
    check("R9 chg pulse", last_chg, 1);
    @(negedge clk);
    check("R9 chg one cycle", cfg_chg, 0);
    scan(8'h80, 8'h04, 0, 0, 0);
    check("R9 no chg unchanged", last_chg, 0);
  endtask

  task automatic t_disagree();
    scan(8'h02, 8'h04, 0, 0, 0);
    scan(8'h10, 8'h04, 0, 0, 0);
    check("R8 disagree holds", func, 1);
    scan(8'h10, 8'h04, 0, 0, 0);
    check("R8 agree commits time interval", func, 3);
  endtask

  task automatic t_func_map();
    int digs[6] = '{0, 7, 1, 4, 3, 2};
    for (int i = 0; i < 6; i++) begin
      scan(8'(1 << digs[i]), 8'h04, 0, 0, 0);
      scan(8'(1 << digs[i]), 8'h04, 0, 0, 0);
      check("R3 function code", func, i);
      check("R9 chg on function change", last_chg, 1);
    end
    scan(8'h12, 8'h04, 0, 0, 0);
    scan(8'h12, 8'h04, 0, 0, 0);
    check("R3 last function digit wins", func, 3);
  endtask

  task automatic t_range_map();
    for (int r = 0; r < 4; r++) begin
      scan(8'h12, 8'(1 << r), 0, 0, 0);
      scan(8'h12, 8'(1 << r), 0, 0, 0);
      check("R4 range step", range_sel, r);
      check("R9 chg on range change", last_chg, 1);
    end
    scan(0, 0, 0, 0, 0);
    scan(0, 0, 0, 0, 0);
    check("R10 func kept", func, 3);
    check("R10 range kept", range_sel, 3);
    check("R10 no chg", last_chg, 0);
  endtask

  task automatic t_control();
    scan(0, 0, 8'h87, 0, 0);
    scan(0, 0, 8'h87, 0, 0);
    check("R5 flags accumulate", {disp_off, disp_test, sel_1mhz, ext_osc, xdp_en}, 5'b01111);
    scan(0, 0, 8'h08, 0, 0);
    scan(0, 0, 8'h08, 0, 0);
    check("R11 D4 without hold", {disp_off, disp_test, sel_1mhz, ext_osc, xdp_en}, 0);
  endtask

  task automatic t_xdp();
    scan(0, 0, 0, 8'h04, 0);
    scan(0, 0, 0, 8'h04, 0);
    check("R7 xdp valid", xdp_valid, 1);
    check("R7 xdp digit D3", xdp_digit, 2);
    scan(0, 0, 0, 8'h80, 0);
    scan(0, 0, 0, 8'h80, 0);
    check("R7 D8 rejected", xdp_valid, 0);
    scan(0, 0, 0, 8'h82, 0);
    scan(0, 0, 0, 8'h82, 0);
    check("R7 D8 ignored with D2", {xdp_valid, xdp_digit}, {1'b1, 3'd1});
  endtask

  task automatic t_strobe_only();
    scan(8'h08, 8'h01, 0, 0, 1);
    scan(8'h08, 8'h01, 0, 0, 1);
    check("R2 func from strobed samples", func, 4);
    check("R2 range from strobed samples", range_sel, 0);
    check("R2 no flags from unstrobed", {disp_off, disp_test, sel_1mhz, ext_osc, xdp_en}, 0);
    check("R2 no xdp from unstrobed", xdp_valid, 0);
  endtask

  task automatic t_polarity();
    active_low = 1'b1;
    scan(8'h04, 8'h01, 8'h02, 0, 0);
    scan(8'h04, 8'h01, 8'h02, 0, 0);
    check("R6 active low func", func, 5);
    check("R6 active low flag", sel_1mhz, 1);
    check("R6 idle high lines not active", xdp_valid, 0);
    active_low = 1'b0;
  endtask

  task automatic t_disp_off();
    hold = 1'b1;
    scan(8'h04, 8'h01, 8'h08, 0, 0);
    scan(8'h04, 8'h01, 8'h08, 0, 0);
    check("R11 display off set", disp_off, 1);
    scan(8'h80, 8'h08, 8'h80, 0, 0);
    scan(8'h80, 8'h08, 8'h80, 0, 0);
    check("R11 lines ignored func", func, 5);
    check("R11 lines ignored range", range_sel, 0);
    check("R11 lines ignored flag", disp_test, 0);
    check("R11 no chg while off", last_chg, 0);
    hold = 1'b0;
    @(negedge clk);
    check("R11 released", disp_off, 0);
    scan(8'h80, 8'h01, 0, 0, 0);
    check("R11 fresh scans needed", func, 5);
    scan(8'h80, 8'h01, 0, 0, 0);
    check("R11 decoding resumed", func, 1);
    check("R9 chg after resume", last_chg, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_agree();
    t_disagree();
    t_func_map();
    t_range_map();
    t_control();
    t_xdp();
    t_strobe_only();
    t_polarity();
    t_disp_off();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule